// File: doc/BRIEF.md
# Multiplexed Interrupt Source Controller

This block gathers event pulses from five interrupt sources and drives one active-low request line to a host controller. The sources fall into groups. Over-temperature prewarning and supply under-voltage are always enabled. The high-side driver group, the LIN group and the over-voltage source can each be enabled or disabled through a 4-bit mask. Every event sets a sticky flag, whether or not its group is enabled.

The host finds the cause of an interrupt through a single 4-bit source code. This code names the highest-priority pending flag. A read strobe returns the code and clears the flag it names. A write strobe loads the mask and also returns the current code. When a read clears one source while an enabled source is still pending, the request line is released for a fixed number of clock cycles and then pulled low again. The host therefore sees a new falling edge for each source it has to service.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset, all mask bits are 1 (every group enabled), `rsp_data` is 0 and `irq_n` is high.
- R2: Mask bit 3 enables the high-side source (index 2), bit 1 the LIN source (index 3) and bit 0 the over-voltage source (index 4). A 1 enables the source. Bit 2 has no effect on any source.
- R3: An event on a disabled source still sets its flag, and the flag is still reported in the source code, but it does not pull `irq_n` low.
- R4: Source 0 (temperature prewarning) and source 1 (supply under-voltage) pull `irq_n` low whatever the mask holds.
- R5: The source code is the index plus one of the lowest-index pending flag, so index 0 has the highest priority. The code is 0 when no flag is pending.
- R6: A read strobe loads the current code into `rsp_data` on the next clock edge and clears the flag that the code names.
- R7: A write strobe stores `wr_data` as the mask and loads the current code into `rsp_data`. It clears no flag.
- R8: After a read that leaves an enabled flag pending, `irq_n` is high for exactly `GAP_CYC` cycles and then goes low. An event that arrives during this gap does not shorten it.
- R9: After a read that leaves no enabled flag pending, `irq_n` is high from the next cycle on.
- R10: A flag whose event arrives in the same cycle as its read stays pending.
- R11: Outside a gap, `irq_n` is low exactly when at least one enabled flag is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 5 | One-cycle event pulses, index 0 to 4 |
| rd_stb | input | 1 | Read of the source code (acknowledge) |
| wr_stb | input | 1 | Write of the mask |
| wr_data | input | 4 | Mask value for a write |
| rsp_data | output | 4 | Response word: code captured at the last strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench sweeps every combination of the five flags against all sixteen mask values. For each case it drains the flags by repeated reads and checks the code order, the mask effect and the length of every gap. An error in the mask bit map, or a missing exemption for the two fixed sources, shows up as a request line that is wrong for some pattern. A design that reported flags in the wrong order, or that ignored disabled flags in the code, would return the wrong response word. Two directed cases check the gap and the acknowledge. In the first, an event arrives mid-gap; a timer that restarts or ends early on new events would move the falling edge. In the second, an event arrives in the same cycle as its read; a design that gave the clear priority would lose that interrupt.

// File: rtl/irq_src_pkg.sv
// Package: source count, code and mask widths, and the map from sources to mask bits.
// Assumes source index 0 has the highest priority.
package irq_src_pkg;
    localparam int NUM_SRC = 5;
    localparam int CODE_W  = 4;
    localparam int MASK_W  = 4;
    // Sources that the mask can disable (index 2: high side, 3: LIN, 4: over-voltage).
    localparam logic [NUM_SRC-1:0] MASKABLE = 5'b11100;
    // Mask bit position for each source. The entry is unused for sources that cannot be masked.
    localparam int MASK_POS [NUM_SRC] = '{0, 0, 3, 1, 0};

    // Derive the enable for each source from the mask register.
    function automatic logic [NUM_SRC-1:0] group_enables(input logic [MASK_W-1:0] m);
        logic [NUM_SRC-1:0] en;
        for (int i = 0; i < NUM_SRC; i++) begin
            en[i] = MASKABLE[i] ? m[MASK_POS[i]] : 1'b1;
        end
        return en;
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
// Sticky flag for each source. In the same cycle, set wins over clear, so an
// event that arrives with its acknowledge is kept.
module irq_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold one source flag: set on an event, clear on its acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_o[g] <= 1'b0;
            else if (set_i[g])   flags_o[g] <= 1'b1;
            else if (clr_i[g])   flags_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder. It selects the lowest-index pending flag, gives it as a
// one-hot vector and as the code index+1. The code is 0 when no flag is set.
module irq_prio_enc #(
    parameter int N      = 5,
    parameter int CODE_W = 4
) (
    input  logic [N-1:0]      flags_i,
    output logic [N-1:0]      sel_o,
    output logic [CODE_W-1:0] code_o
);
    // Scan from the lowest priority upward so that the lowest index set wins.
    always_comb begin
        sel_o  = '0;
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags_i[i]) begin
                sel_o    = '0;
                sel_o[i] = 1'b1;
                code_o   = CODE_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/irq_gap_timer.sv
// Release timer. A start loads GAP_CYC, and active_o stays high until the count
// reaches zero. Only a new start reloads the count.
module irq_gap_timer #(
    parameter int GAP_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(GAP_CYC + 1);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start_i)       cnt_q <= CNT_W'(GAP_CYC);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/irq_src_ctrl.sv
// Top level: masked, multiplexed interrupt source controller.
// It assumes single-cycle strobes from a register access front end. If both
// strobes are high in one cycle, the read takes effect and the mask is also written.
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter int GAP_CYC = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               rd_stb,
    input  logic               wr_stb,
    input  logic [MASK_W-1:0]  wr_data,
    output logic [CODE_W-1:0]  rsp_data,
    output logic               irq_n
);
    logic [MASK_W-1:0]  mask_q;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] sel_onehot;
    logic [NUM_SRC-1:0] ack_vec;
    logic [NUM_SRC-1:0] remain;
    logic [CODE_W-1:0]  cur_code;
    logic               gap_start;
    logic               gap_active;

    // Mask register: all groups enabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '1;
        else if (wr_stb) mask_q <= wr_data;
    end

    assign en_vec = group_enables(mask_q);

    irq_flag_bank #(.N(NUM_SRC)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_evt),
        .clr_i   (ack_vec),
        .flags_o (flags)
    );

    irq_prio_enc #(.N(NUM_SRC), .CODE_W(CODE_W)) i_enc (
        .flags_i (flags),
        .sel_o   (sel_onehot),
        .code_o  (cur_code)
    );

    // A read acknowledges exactly the source that it reports.
    assign ack_vec   = rd_stb ? sel_onehot : '0;
    assign remain    = ((flags & ~ack_vec) | src_evt) & en_vec;
    assign gap_start = rd_stb && (|sel_onehot) && (|remain);

    irq_gap_timer #(.GAP_CYC(GAP_CYC)) i_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (gap_start),
        .active_o (gap_active)
    );

    // Response word: the code captured on either strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                rsp_data <= '0;
        else if (rd_stb || wr_stb) rsp_data <= cur_code;
    end

    assign irq_n = !((|(flags & en_vec)) && !gap_active);
endmodule

// Checker module with the assertions for irq_src_ctrl.
module irq_src_ctrl_chk #(
    parameter int N      = 5,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [N-1:0]      src_evt,
    input logic [N-1:0]      flags,
    input logic [N-1:0]      en_vec,
    input logic [N-1:0]      sel_onehot,
    input logic [CODE_W-1:0] cur_code,
    input logic              gap_active,
    input logic [CODE_W-1:0] rsp_data,
    input logic              irq_n
);
    assert_code_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> (cur_code == '0));
    assert_single_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_onehot));
    assert_rsp_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |=> (rsp_data == $past(cur_code)));
    assert_gap_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gap_active |-> irq_n);
    assert_irq_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (|(flags & en_vec)));
    assert_release_by_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_n) && (|(flags & en_vec))) |-> $past(rd_stb));
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (|sel_onehot) && !(|(src_evt & sel_onehot)))
        |=> !(|(flags & $past(sel_onehot))));
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(.N(irq_src_pkg::NUM_SRC), .CODE_W(irq_src_pkg::CODE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .src_evt    (src_evt),
    .flags      (flags),
    .en_vec     (en_vec),
    .sel_onehot (sel_onehot),
    .cur_code   (cur_code),
    .gap_active (gap_active),
    .rsp_data   (rsp_data),
    .irq_n      (irq_n)
);

// File: tb/test_irq_src_ctrl.sv
// Bench: sweeps all flag patterns against all mask values, then runs directed gap cases.
module test_irq_src_ctrl;
    localparam int GAP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_evt = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [3:0] wr_data = '0;
    logic [3:0] rsp_data;
    logic       irq_n;

    int nchk = 0;
    int nerr = 0;
    logic [4:0] ef = '0;        // expected flags
    logic [3:0] em = 4'hF;      // expected mask

    irq_src_ctrl #(.GAP_CYC(GAP)) i_irq_src_ctrl (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .rsp_data(rsp_data), .irq_n(irq_n)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] exp_code(input logic [4:0] f);
        for (int i = 0; i < 5; i++) if (f[i]) return 4'(i + 1);
        return 4'h0;
    endfunction

    function automatic logic [4:0] exp_en(input logic [3:0] m);
        return {m[0], m[1], m[3], 1'b1, 1'b1};
    endfunction

    function automatic logic exp_irq_n(input logic [4:0] f, input logic [3:0] m);
        return !(|(f & exp_en(m)));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Expect irq_n high for the rest of a gap, then low. Called after `done` cycles of the gap.
    task automatic expect_gap(input int done);
        chk("R8 gap high", irq_n, 1'b1);
        repeat (GAP - 1 - done) tick();
        chk("R8 gap still high", irq_n, 1'b1);
        tick();
        chk("R8 reassert", irq_n, 1'b0);
    endtask

    // Read one source and check the response, the clear and the request line.
    task automatic do_read();
        logic [3:0] c;
        c = exp_code(ef);
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
        chk("R6 read response", rsp_data, c);
        ef = ef & ~(ef & (~ef + 5'd1));
        if ((ef & exp_en(em)) != '0) expect_gap(0);
        else chk("R9 release", irq_n, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick();
        // R1: reset state
        chk("R1 rsp reset", rsp_data, 4'h0);
        chk("R1 irq reset", irq_n, 1'b1);
        rst_n = 1'b1;
        tick();
        chk("R1 irq idle", irq_n, 1'b1);
        // R1: over-voltage enabled by the reset mask
        src_evt = 5'b10000; tick(); src_evt = '0; ef = 5'b10000;
        chk("R1 mask reset enables bit0", irq_n, 1'b0);
        do_read();

        // Sweep: every flag pattern against every mask value
        for (int p = 0; p < 32; p++) begin
            for (int m = 0; m < 16; m++) begin
                src_evt = 5'(p); tick(); src_evt = '0; ef = 5'(p);
                chk("R3 R4 R11 irq after events", irq_n, exp_irq_n(ef, em));
                wr_data = 4'(m); wr_stb = 1'b1; tick(); wr_stb = 1'b0;
                chk("R7 write response", rsp_data, exp_code(ef));
                em = 4'(m);
                chk("R2 mask effect", irq_n, exp_irq_n(ef, em));
                while (ef != '0) do_read();
                chk("R7 write kept nothing extra", irq_n, 1'b1);
            end
        end
        // R5: read with nothing pending returns 0
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk("R5 empty code", rsp_data, 4'h0);

        // R8: an event during the gap does not shorten it
        wr_data = 4'hF; wr_stb = 1'b1; tick(); wr_stb = 1'b0; em = 4'hF;
        src_evt = 5'b10100; tick(); src_evt = '0; ef = 5'b10100;
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk("R6 first of two", rsp_data, 4'h3);
        ef = 5'b10000;
        chk("R8 gap start", irq_n, 1'b1);
        repeat (3) tick();
        src_evt = 5'b00001; tick(); src_evt = '0; ef = 5'b10001;
        chk("R8 arrival in gap keeps high", irq_n, 1'b1);
        expect_gap(4);
        do_read();
        chk("R5 priority after arrival", rsp_data, 4'h1);
        do_read();

        // R10: event in the same cycle as its acknowledge stays pending
        src_evt = 5'b01000; tick(); src_evt = '0; ef = 5'b01000;
        rd_stb = 1'b1; src_evt = 5'b01000; tick(); rd_stb = 1'b0; src_evt = '0;
        chk("R10 response", rsp_data, 4'h4);
        expect_gap(0);
        chk("R10 still pending", irq_n, 1'b0);
        do_read();
        chk("R10 cleared later", rsp_data, 4'h4);

        finish_run();
    end
endmodule